// File: doc/BRIEF.md
# Frequency Lock Detector with Reacquisition

This block decides whether a clock-recovery loop is frequency locked by counting the edges of its recovered clock against a fixed span of reference-clock cycles. The recovered clock is first divided by a selectable ratio of 16, 32 or 128, which is the ratio between the data rate and the reference frequency. The divided edges are counted in the recovered-clock domain and brought into the reference domain through a Gray-code synchronizer. At the end of every window of `WIN_CYCLES` reference cycles, the count gained during that window is compared with `WIN_CYCLES`. Only frequency is judged. Phase plays no part.

The loss-of-lock flag is active high, and it is set when reset is released. One window whose count error exceeds the unlock threshold sets it again. Two back-to-back windows within the tighter lock threshold clear it. Errors that fall between the two thresholds change nothing. The thresholds are given in counts: a tolerance of `p` ppm corresponds to `p * WIN_CYCLES / 1e6` counts. While the flag is set, the block emits a one-cycle reacquire request every `REACQ_WINDOWS` windows. Power-down or calibration forces the flag low and suppresses requests. When both are released, measurement restarts from a fresh window and lock has to be confirmed again.

Top module: `freq_lock_mon`

## Requirements
- R1: During reset and in the first cycles after it, `lossOfLock` is 1 and `reacqPulse` is 0.
- R2: `divSel` picks the divide ratio: 0 gives 16, 1 gives 32, and 2 or 3 give 128. A recovered clock at exactly ratio times the reference frequency gives a window count of `WIN_CYCLES`.
- R3: The count error of a window is |count − `WIN_CYCLES`|. A recovered clock at half the selected rate (count `WIN_CYCLES`/2) is reported as loss of lock.
- R4: One window with an error above `UNLOCK_TOL` sets `lossOfLock` at the reference edge after that window's result is registered.
- R5: Hysteresis. An error above `LOCK_TOL` but not above `UNLOCK_TOL` leaves a locked block locked, and it never releases an unlocked block.
- R6: `lossOfLock` is released only after `CONFIRM_WINDOWS` (2) consecutive windows with error at most `LOCK_TOL`. The flag is still 1 after the first such window.
- R7: While `pwrDown` or `calib` is 1, `lossOfLock` is 0 and `reacqPulse` is 0, whatever the recovered clock does.
- R8: Releasing both holds restarts the window from zero and treats the loop as unlocked internally. The flag reads 1 one window after release and clears no earlier than two good windows after release.
- R9: While the internal loss-of-lock state is set and no hold is active, `reacqPulse` is high for exactly one reference cycle at the end of every `REACQ_WINDOWS`-th window, counted from the last restart. No pulse occurs while locked.
- R10: Recovered-clock offsets of ±600 ppm are measured without counter overflow. A nominal clock offset by ±600 ppm stays within the lock tolerance, and the Gray counter changes one bit at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; all control logic runs on it |
| recClk | input | 1 | Recovered clock from the loop, at the data rate |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 2 | Divide ratio select: 0 → 16, 1 → 32, 2/3 → 128 |
| pwrDown | input | 1 | Power-down hold, synchronous to refClk |
| calib | input | 1 | Calibration hold, synchronous to refClk |
| lossOfLock | output | 1 | Active-high loss-of-lock flag |
| reacqPulse | output | 1 | One-reference-cycle reacquire request |

## Verification
The assertions take for granted that `pwrDown`, `calib` and `divSel` change only on reference-clock timing, and that `divSel` changes only while a window result is not needed. They also rely on the recovered clock staying below twice the nominal rate, so a window count always lies below 2·`WIN_CYCLES`. The stimulus changes holds and the select on the falling reference edge. Its largest recovered-clock deviation is +5 %, plus a half-rate mismatch. Every frequency or select change is followed by at least one full window before a verdict is read.

// File: rtl/flm_pkg.sv
package flm_pkg;
  timeunit 1ns;
  timeprecision 1fs;

  // Largest divide ratio and the width of the divider counter
  localparam int MAX_RATIO = 128;
  localparam int DIV_W     = $clog2(MAX_RATIO);

  // Control-to-datapath strobes
  typedef struct packed {
    logic restart;   // reload the baseline, window counter held at zero
    logic winEnd;    // last reference cycle of a measurement window
  } flmStrobe_t;

  // Datapath verdict for one window
  typedef struct packed {
    logic valid;     // one cycle after winEnd
    logic tight;     // error within the lock threshold
    logic loose;     // error beyond the unlock threshold
  } flmMeas_t;

  function automatic int ratioOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 32;
      default: return MAX_RATIO;
    endcase
  endfunction
endpackage

// File: rtl/flm_rec_counter.sv
module flm_rec_counter
  import flm_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             recClk,
  input  logic             rstN,
  input  logic [1:0]       divSel,
  output logic [CNT_W-1:0] grayOut
);
  timeunit 1ns;
  timeprecision 1fs;

  logic [1:0]       rstSync;
  logic             recRstN;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic [CNT_W-1:0] binCnt;
  logic [CNT_W-1:0] binNext;

  // Reset release synchronized into the recovered-clock domain
  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) rstSync <= 2'b00;
    else       rstSync <= {rstSync[0], 1'b1};
  end
  assign recRstN = rstSync[1];

  // divSel is quasi-static; compare with >= so a ratio change never stalls
  always_comb begin
    divLast = DIV_W'(ratioOf(divSel) - 1);
    binNext = binCnt + CNT_W'(1);
  end

  always_ff @(posedge recClk or negedge recRstN) begin
    if (!recRstN) begin
      divCnt  <= '0;
      binCnt  <= '0;
      grayOut <= '0;
    end else if (divCnt >= divLast) begin
      divCnt  <= '0;
      binCnt  <= binNext;
      grayOut <= binNext ^ (binNext >> 1);
    end else begin
      divCnt  <= divCnt + DIV_W'(1);
    end
  end

  // R10
  gray_step_chk: assert property (@(posedge recClk) disable iff (!recRstN)
    !$stable(grayOut) |-> $countones(grayOut ^ $past(grayOut)) == 1);
endmodule

// File: rtl/flm_datapath.sv
module flm_datapath
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES = 4096,
  parameter int LOCK_TOL   = 4,
  parameter int UNLOCK_TOL = 8,
  parameter int CNT_W      = 14
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] recGray,
  input  flmStrobe_t       strobe,
  output flmMeas_t         meas
);
  timeunit 1ns;
  timeprecision 1fs;

  localparam logic [CNT_W-1:0] WIN_VAL   = CNT_W'(WIN_CYCLES);
  localparam logic [CNT_W-1:0] LOCK_VAL  = CNT_W'(LOCK_TOL);
  localparam logic [CNT_W-1:0] UNLK_VAL  = CNT_W'(UNLOCK_TOL);
  localparam logic [CNT_W-1:0] LIMIT_VAL = CNT_W'(2 * WIN_CYCLES);

  logic [CNT_W-1:0] graySync1, graySync2;
  logic [CNT_W-1:0] syncBin;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] winCount;
  logic [CNT_W-1:0] errAbs;
  logic [CNT_W-1:0] lastCount;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
    end else begin
      graySync1 <= recGray;
      graySync2 <= graySync1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits
  always_comb begin
    for (int i = 0; i < CNT_W; i++) syncBin[i] = ^(graySync2 >> i);
    winCount = syncBin - baseCnt;
    errAbs   = (winCount >= WIN_VAL) ? (winCount - WIN_VAL) : (WIN_VAL - winCount);
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      baseCnt   <= '0;
      lastCount <= '0;
      meas      <= '0;
    end else begin
      meas.valid <= strobe.winEnd;
      if (strobe.restart || strobe.winEnd) baseCnt <= syncBin;
      if (strobe.winEnd) begin
        meas.tight <= (errAbs <= LOCK_VAL);
        meas.loose <= (errAbs >  UNLK_VAL);
        lastCount  <= winCount;
      end
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge refClk) disable iff (!rstN)
    meas.valid |-> lastCount < LIMIT_VAL);

  // R3
  meas_spacing_chk: assert property (@(posedge refClk) disable iff (!rstN)
    meas.valid |=> !meas.valid);
endmodule

// File: rtl/flm_ctrl.sv
module flm_ctrl
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES      = 4096,
  parameter int REACQ_WINDOWS   = 8,
  parameter int CONFIRM_WINDOWS = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       hold,
  input  flmMeas_t   meas,
  output flmStrobe_t strobe,
  output logic       lolState,
  output logic       reacqPulse
);
  timeunit 1ns;
  timeprecision 1fs;

  localparam int WIN_W  = $clog2(WIN_CYCLES);
  localparam int REQ_W  = $clog2(REACQ_WINDOWS + 1);
  localparam int CONF_W = $clog2(CONFIRM_WINDOWS + 1);

  logic              armed;
  logic [WIN_W-1:0]  winCnt;
  logic [REQ_W-1:0]  reqCnt;
  logic [CONF_W-1:0] goodCnt;

  always_comb begin
    strobe.restart = hold || !armed;
    strobe.winEnd  = !strobe.restart && (winCnt == WIN_W'(WIN_CYCLES - 1));
  end

  // Window timing
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      winCnt <= '0;
    end else begin
      armed <= 1'b1;
      if (strobe.restart || strobe.winEnd) winCnt <= '0;
      else                                 winCnt <= winCnt + WIN_W'(1);
    end
  end

  // Lock state with hysteresis and confirmation
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      lolState <= 1'b1;
      goodCnt  <= '0;
    end else if (hold) begin
      lolState <= 1'b1;
      goodCnt  <= '0;
    end else if (meas.valid) begin
      if (lolState) begin
        if (!meas.tight) begin
          goodCnt <= '0;
        end else if (goodCnt == CONF_W'(CONFIRM_WINDOWS - 1)) begin
          lolState <= 1'b0;
          goodCnt  <= '0;
        end else begin
          goodCnt <= goodCnt + CONF_W'(1);
        end
      end else if (meas.loose) begin
        lolState <= 1'b1;
        goodCnt  <= '0;
      end
    end
  end

  // Reacquire request scheduler
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      reqCnt     <= '0;
      reacqPulse <= 1'b0;
    end else if (hold || !lolState) begin
      reqCnt     <= '0;
      reacqPulse <= 1'b0;
    end else begin
      reacqPulse <= 1'b0;
      if (strobe.winEnd) begin
        if (reqCnt == REQ_W'(REACQ_WINDOWS - 1)) begin
          reqCnt     <= '0;
          reacqPulse <= 1'b1;
        end else begin
          reqCnt <= reqCnt + REQ_W'(1);
        end
      end
    end
  end

  // R6
  lol_release_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lolState) |-> $past(meas.valid && meas.tight));

  // R4
  lol_set_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lolState) |-> $past(hold || (meas.valid && meas.loose)));

  // R9
  reacq_width_chk: assert property (@(posedge refClk) disable iff (!rstN)
    reacqPulse |=> !reacqPulse);

  // R9
  reacq_cond_chk: assert property (@(posedge refClk) disable iff (!rstN)
    reacqPulse |-> $past(lolState && !hold));

  // R8
  restart_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(hold) |-> lolState);
endmodule

// File: rtl/freq_lock_mon.sv
module freq_lock_mon
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES      = 4096,
  parameter int LOCK_TOL        = 4,
  parameter int UNLOCK_TOL      = 8,
  parameter int REACQ_WINDOWS   = 8,
  parameter int CONFIRM_WINDOWS = 2
) (
  input  logic       refClk,
  input  logic       recClk,
  input  logic       rstN,
  input  logic [1:0] divSel,
  input  logic       pwrDown,
  input  logic       calib,
  output logic       lossOfLock,
  output logic       reacqPulse
);
  timeunit 1ns;
  timeprecision 1fs;

  localparam int CNT_W = $clog2(WIN_CYCLES) + 2;

  logic             hold;
  logic             lolState;
  logic [CNT_W-1:0] recGray;
  flmStrobe_t       strobe;
  flmMeas_t         meas;

  assign hold       = pwrDown || calib;
  assign lossOfLock = lolState && !hold;

  flm_rec_counter #(.CNT_W(CNT_W)) recCnt_i (
    .recClk (recClk),
    .rstN   (rstN),
    .divSel (divSel),
    .grayOut(recGray)
  );

  flm_datapath #(
    .WIN_CYCLES(WIN_CYCLES),
    .LOCK_TOL  (LOCK_TOL),
    .UNLOCK_TOL(UNLOCK_TOL),
    .CNT_W     (CNT_W)
  ) dp_i (
    .refClk (refClk),
    .rstN   (rstN),
    .recGray(recGray),
    .strobe (strobe),
    .meas   (meas)
  );

  flm_ctrl #(
    .WIN_CYCLES     (WIN_CYCLES),
    .REACQ_WINDOWS  (REACQ_WINDOWS),
    .CONFIRM_WINDOWS(CONFIRM_WINDOWS)
  ) ctrl_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .hold      (hold),
    .meas      (meas),
    .strobe    (strobe),
    .lolState  (lolState),
    .reacqPulse(reacqPulse)
  );
endmodule

// File: tb/freq_lock_mon_tb_top.sv
module freq_lock_mon_tb_top;
  timeunit 1ns;
  timeprecision 1fs;

  localparam int WIN   = 256;
  localparam int LTOL  = 2;
  localparam int UTOL  = 6;
  localparam int REACQ = 3;

  logic       refClk  = 1'b0;
  logic       recClk  = 1'b0;
  logic       rstN    = 1'b0;
  logic       pwrDown = 1'b0;
  logic       calib   = 1'b0;
  logic [1:0] divSel  = 2'd0;
  wire        lossOfLock;
  wire        reacqPulse;

  realtime recHalf = 0.25;
  int  testsRun    = 0;
  int  testsFailed = 0;
  int  pulseCnt    = 0;
  int  widthErrs   = 0;
  bit  countOn     = 1'b0;
  bit  prevPulse   = 1'b0;

  always #4 refClk = ~refClk;           // 125 MHz
  always #(recHalf) recClk = ~recClk;

  always @(negedge refClk) begin
    if (countOn && reacqPulse) pulseCnt++;
    if (countOn && reacqPulse && prevPulse) widthErrs++;
    prevPulse = reacqPulse;
  end

  freq_lock_mon #(
    .WIN_CYCLES(WIN), .LOCK_TOL(LTOL), .UNLOCK_TOL(UTOL),
    .REACQ_WINDOWS(REACQ), .CONFIRM_WINDOWS(2)
  ) dut_i (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .divSel(divSel),
    .pwrDown(pwrDown), .calib(calib),
    .lossOfLock(lossOfLock), .reacqPulse(reacqPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge refClk);
  endtask

  // Recovered clock at ratio * reference frequency, offset by ppm
  task automatic setRec(input int ratio, input real ppm);
    recHalf = 4.0 / (ratio * (1.0 + ppm * 1.0e-6));
  endtask

  // Pulse calib; the first posedge after the return starts the new window
  task automatic holdRelease();
    @(negedge refClk);
    calib = 1'b1;
    waitCycles(4);
    calib = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    waitCycles(10);
    check("R1 lol during reset", lossOfLock, 1);
    check("R1 reacq during reset", reacqPulse, 0);
    rstN = 1'b1;
    waitCycles(3);
    check("R1 lol after reset", lossOfLock, 1);
  endtask

  task automatic t_ratios();
    for (int s = 0; s < 4; s++) begin
      int ratio;
      ratio  = (s == 0) ? 16 : (s == 1) ? 32 : 128;
      divSel = 2'(s);
      setRec(ratio, 0.0);
      waitCycles(8);
      holdRelease();
      waitCycles(2 * WIN - 4);
      check($sformatf("R6 still unlocked after one window sel %0d", s), lossOfLock, 1);
      waitCycles(8);
      check($sformatf("R2 locked at ratio %0d", ratio), lossOfLock, 0);
    end
  endtask

  task automatic t_mismatch();
    divSel = 2'd1;
    setRec(16, 0.0);                     // half the expected rate
    waitCycles(2 * WIN + 10);
    check("R3 half-rate clock flagged", lossOfLock, 1);
  endtask

  task automatic t_ppm();
    divSel = 2'd0;
    setRec(16, 600.0);
    waitCycles(8);
    holdRelease();
    waitCycles(2 * WIN + 8);
    check("R10 lock at +600 ppm", lossOfLock, 0);
    setRec(16, -600.0);
    waitCycles(4 * WIN);
    check("R10 lock held at -600 ppm", lossOfLock, 0);
  endtask

  task automatic t_unlock();
    setRec(16, 50000.0);                 // +5 %
    waitCycles(2 * WIN + 10);
    check("R4 single bad window sets lol", lossOfLock, 1);
  endtask

  task automatic t_hysteresis();
    setRec(16, 15625.0);                 // error about 4 counts
    waitCycles(5 * WIN);
    check("R5 mid error does not release", lossOfLock, 1);
    setRec(16, 0.0);
    waitCycles(8);
    holdRelease();
    waitCycles(2 * WIN + 8);
    check("R5 relocked at nominal", lossOfLock, 0);
    setRec(16, 15625.0);
    waitCycles(5 * WIN);
    check("R5 mid error keeps lock", lossOfLock, 0);
  endtask

  task automatic t_hold();
    setRec(16, 50000.0);
    waitCycles(2 * WIN + 10);
    check("R4 lol before hold", lossOfLock, 1);
    @(negedge refClk);
    calib = 1'b1;
    waitCycles(1);
    check("R7 calib forces lol low", lossOfLock, 0);
    calib = 1'b0;
    @(negedge refClk);
    pwrDown  = 1'b1;
    pulseCnt = 0;
    countOn  = 1'b1;
    waitCycles(4 * WIN);
    countOn  = 1'b0;
    check("R7 lol low in power-down", lossOfLock, 0);
    check("R7 no reacq in power-down", pulseCnt, 0);
    setRec(16, 0.0);
    waitCycles(8);
    pwrDown = 1'b0;
    waitCycles(WIN + 4);
    check("R8 reconfirm needed after restart", lossOfLock, 1);
    waitCycles(WIN + 4);
    check("R8 lock after two windows", lossOfLock, 0);
  endtask

  task automatic t_reacq();
    setRec(16, 50000.0);
    waitCycles(8);
    holdRelease();
    pulseCnt  = 0;
    widthErrs = 0;
    countOn   = 1'b1;
    waitCycles(9 * WIN + 10);
    countOn   = 1'b0;
    check("R9 pulses in nine windows", pulseCnt, 3);
    check("R9 pulse width one cycle", widthErrs, 0);
    setRec(16, 0.0);
    waitCycles(8);
    holdRelease();
    waitCycles(2 * WIN + 8);
    check("R9 locked before quiet check", lossOfLock, 0);
    pulseCnt = 0;
    countOn  = 1'b1;
    waitCycles(6 * WIN);
    countOn  = 1'b0;
    check("R9 no pulses while locked", pulseCnt, 0);
  endtask

  initial begin
    #(8.0 * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    t_reset();
    t_ratios();
    t_mismatch();
    t_ppm();
    t_unlock();
    t_hysteresis();
    t_hold();
    t_reacq();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule